// File: doc/BRIEF.md
# Sixteen-Line Edge-Interrupt GPIO Controller

This block is a memory-mapped general-purpose I/O peripheral for sixteen lines. Software configures each line as an input or an output, sets the level that output lines drive, and picks for each input line whether a rising or a falling transition raises an interrupt. The block samples the external lines through a two-stage synchroniser. It finds transitions by comparing each new synchronised sample with the one before it.

A transition is recorded in a status register only when three conditions hold at that moment: the line is an input, its mask bit is clear, and the transition has the selected polarity. Masked transitions are dropped and are not stored for later. Software clears recorded events by writing ones to the status register. The single interrupt output is a registered OR of all status bits.

The register bus is a simple strobe interface. An access is a single valid cycle carrying a write flag, an address, a size code and write data. Read data appears on the cycle after the strobe. Only half-word (16-bit) accesses are acted on.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: The register offsets are 0x00 line input (read-only), 0x04 output data, 0x08 direction, 0x0C edge polarity, 0x10 interrupt mask, 0x14 interrupt status and 0x18 pin enable. A read of any other offset returns zero, and a write to any other offset changes no register.
- R2: A direction bit of 1 makes its line an input and a 0 makes it an output. `pin_out` always equals output data AND NOT direction, so every line set to input drives 0.
- R3: A polarity bit of 1 records rising transitions on its line. A polarity bit of 0 records falling transitions on that line. A transition of the other polarity records nothing.
- R4: A status bit is set only when its line is an input, its mask bit is 0 and the selected transition is detected. A transition seen while the line is masked, or while the line is an output, is never recorded, even after the mask is later cleared.
- R5: A write to the status offset clears each bit written as 1 and keeps each bit written as 0. If a new transition and a clear of the same bit occur in the same cycle, the bit ends set. `irq` goes low one cycle after the status register becomes all zero.
- R6: A read of offset 0x00 returns the synchronised line samples ANDed with pin enable. Writes to offset 0x00 have no effect.
- R7: After reset, output data, direction, polarity, mask and pin enable read 0xFFFF. The input samples, the status register, `irq` and `pin_out` are 0.
- R8: Only accesses with `bus_size` = 2'b01 (16-bit) are acted on. A read with any other size code returns zero, and a write with any other size code is ignored.
- R9: A change on `pin_in` set up before clock edge k is recorded in status at edge k+2 and raises `irq` at edge k+3.
- R10: A write takes effect at the clock edge that samples the strobe, so `pin_out` reflects it at once. Read data is registered at that same edge and holds until the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access size code, 2'b01 = 16 bits |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Asynchronous external line levels |
| pin_out | output | 16 | Driven line levels, gated by direction |
| irq | output | 1 | Level interrupt, OR of status |

## Verification
Configuration writes show on `pin_out` right after the clock edge that samples the strobe. Read data is due one edge after the strobe. The bench drives every access at a falling edge and reads its result at the next falling edge. A line change driven before edge k must show in status after edge k+2 and on `irq` after edge k+3. The bench counts edges explicitly after each pin change and checks that `irq` is still low one edge before it is due and high when it is due. The case where a clear and a new transition meet in one cycle is set up by timing the clear write so that it lands on the exact edge where the transition is detected.

// File: rtl/gpio_ctrl_pkg.sv
// Package: shared constants and types for the edge-interrupt GPIO controller.
// Assumes byte offsets fit in eight bits; the register decode does not
// depend on the address width beyond that.
package gpio_ctrl_pkg;

    // Byte offsets of the register file
    localparam int OFS_LINE_IN = 'h00;
    localparam int OFS_OUT     = 'h04;
    localparam int OFS_DIR     = 'h08;
    localparam int OFS_POL     = 'h0C;
    localparam int OFS_MASK    = 'h10;
    localparam int OFS_STAT    = 'h14;
    localparam int OFS_PEN     = 'h18;

    // Access size codes on the register bus
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } bus_size_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Brings asynchronous line levels into the clock domain through a chain of
// STAGES flops per line and keeps one more flop holding the previous
// synchronised sample for transition detection.
// Assumes STAGES >= 2 and that lines are slow compared to the clock.
module gpio_in_sync #(
    parameter int LINES  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] cur_smp,
    output logic [LINES-1:0] prev_smp
);

    logic [LINES-1:0] chain [STAGES];

    // First stage captures the raw level
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= raw_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage re-times the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign cur_smp = chain[STAGES-1];

    // Previous synchronised sample, used to spot transitions
    always_ff @(posedge clk) begin
        if (!rst_n) prev_smp <= '0;
        else        prev_smp <= cur_smp;
    end

endmodule

// File: rtl/gpio_edge_irq.sv
// Module: gpio_edge_irq
// Per line: detects the transition selected by polarity, qualifies it with
// direction and mask at the moment of detection, and latches it in the status
// register. Clears are write-one-to-clear; a new event in the same cycle wins.
// The interrupt is a registered OR of the status bits.
module gpio_edge_irq #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] cur_smp,
    input  logic [LINES-1:0] prev_smp,
    input  logic [LINES-1:0] pol_q,
    input  logic [LINES-1:0] dir_q,
    input  logic [LINES-1:0] mask_q,
    input  logic [LINES-1:0] stat_clr,
    output logic [LINES-1:0] edge_set,
    output logic [LINES-1:0] status_q,
    output logic             irq
);

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            logic rise_l, fall_l, hit_l;
            // Transition of the selected polarity, qualified now
            always_comb begin
                rise_l      = cur_smp[i] & ~prev_smp[i];
                fall_l      = ~cur_smp[i] & prev_smp[i];
                hit_l       = pol_q[i] ? rise_l : fall_l;
                edge_set[i] = hit_l & dir_q[i] & ~mask_q[i];
            end

            // Status bit: set has priority over clear
            always_ff @(posedge clk) begin
                if (!rst_n)            status_q[i] <= 1'b0;
                else if (edge_set[i])  status_q[i] <= 1'b1;
                else if (stat_clr[i])  status_q[i] <= 1'b0;
            end
        end
    endgenerate

    // Registered interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |status_q;
    end

endmodule

// File: rtl/gpio_regfile.sv
// Module: gpio_regfile
// Holds the software-visible configuration registers, decodes the strobe bus,
// produces the status clear vector and the registered read data.
// Assumes one access per strobe cycle; only half-word size is acted on.
module gpio_regfile
    import gpio_ctrl_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [LINES-1:0]  bus_wdata,
    input  logic [LINES-1:0]  cur_smp,
    input  logic [LINES-1:0]  status_q,
    output logic [LINES-1:0]  out_q,
    output logic [LINES-1:0]  dir_q,
    output logic [LINES-1:0]  pol_q,
    output logic [LINES-1:0]  mask_q,
    output logic [LINES-1:0]  pen_q,
    output logic [LINES-1:0]  stat_clr,
    output logic [LINES-1:0]  bus_rdata
);

    logic             size_ok, wr_en, rd_en;
    logic [LINES-1:0] rd_mux;

    // Access qualification
    always_comb begin
        size_ok = bus_valid && (bus_size == SZ_HALF);
        wr_en   = size_ok && bus_write;
        rd_en   = size_ok && !bus_write;
    end

    // Configuration registers, all ones after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '1;
            dir_q  <= '1;
            pol_q  <= '1;
            mask_q <= '1;
            pen_q  <= '1;
        end else if (wr_en) begin
            case (bus_addr)
                ADDR_W'(OFS_OUT):  out_q  <= bus_wdata;
                ADDR_W'(OFS_DIR):  dir_q  <= bus_wdata;
                ADDR_W'(OFS_POL):  pol_q  <= bus_wdata;
                ADDR_W'(OFS_MASK): mask_q <= bus_wdata;
                ADDR_W'(OFS_PEN):  pen_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Write-one-to-clear vector for the status register
    always_comb begin
        stat_clr = (wr_en && bus_addr == ADDR_W'(OFS_STAT)) ? bus_wdata : '0;
    end

    // Read selection, zero for unmapped offsets
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_LINE_IN): rd_mux = cur_smp & pen_q;
            ADDR_W'(OFS_OUT):     rd_mux = out_q;
            ADDR_W'(OFS_DIR):     rd_mux = dir_q;
            ADDR_W'(OFS_POL):     rd_mux = pol_q;
            ADDR_W'(OFS_MASK):    rd_mux = mask_q;
            ADDR_W'(OFS_STAT):    rd_mux = status_q;
            ADDR_W'(OFS_PEN):     rd_mux = pen_q;
            default:              rd_mux = '0;
        endcase
    end

    // Registered read data; bad-size reads return zero
    always_ff @(posedge clk) begin
        if (!rst_n)                      bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_en ? rd_mux : '0;
    end

endmodule

// File: rtl/edge_gpio_ctrl.sv
// Module: edge_gpio_ctrl
// Top of the sixteen-line GPIO controller: synchroniser, register file and
// edge/interrupt logic. Output lines drive output data gated by direction.
// Assumes pin_in is asynchronous and the bus strobe is synchronous to clk.
module edge_gpio_ctrl #(
    parameter int LINES  = 16,
    parameter int ADDR_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic              irq
);

    logic [LINES-1:0] cur_smp, prev_smp;
    logic [LINES-1:0] out_q, dir_q, pol_q, mask_q, pen_q;
    logic [LINES-1:0] stat_clr, edge_set, status_q;

    gpio_in_sync #(.LINES(LINES), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .cur_smp  (cur_smp),
        .prev_smp (prev_smp)
    );

    gpio_regfile #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .cur_smp   (cur_smp),
        .status_q  (status_q),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .pol_q     (pol_q),
        .mask_q    (mask_q),
        .pen_q     (pen_q),
        .stat_clr  (stat_clr),
        .bus_rdata (bus_rdata)
    );

    gpio_edge_irq #(.LINES(LINES)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_smp  (cur_smp),
        .prev_smp (prev_smp),
        .pol_q    (pol_q),
        .dir_q    (dir_q),
        .mask_q   (mask_q),
        .stat_clr (stat_clr),
        .edge_set (edge_set),
        .status_q (status_q),
        .irq      (irq)
    );

    // Output lines drive data only where direction selects output
    assign pin_out = out_q & ~dir_q;

endmodule

// File: rtl/gpio_ctrl_checker.sv
// Module: gpio_ctrl_checker
// Temporal checks on the GPIO controller, bound into edge_gpio_ctrl.
module gpio_ctrl_checker
    import gpio_ctrl_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [LINES-1:0]  bus_wdata,
    input logic [LINES-1:0]  bus_rdata,
    input logic [LINES-1:0]  pin_out,
    input logic              irq,
    input logic [LINES-1:0]  status_q,
    input logic [LINES-1:0]  dir_q,
    input logic [LINES-1:0]  mask_q,
    input logic [LINES-1:0]  edge_set
);

    // A newly set status bit needs an unmasked input line one cycle earlier
    assert_qualified_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q)) & ($past(mask_q) | ~$past(dir_q))) == '0);

    // Cleared bits stay clear unless a new event arrived in that cycle
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size == SZ_HALF && bus_addr == ADDR_W'(OFS_STAT))
        |=> ((status_q & $past(bus_wdata) & ~$past(edge_set)) == '0));

    // The interrupt drops only after status was empty
    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(status_q) == '0));

    // Driven lines change only in response to a write
    assert_out_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> $stable(pin_out));

    // Wrong-size writes leave configuration untouched
    assert_bad_size_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != SZ_HALF)
        |=> ($stable(dir_q) && $stable(mask_q) && $stable(pin_out)));

    // Wrong-size reads return zero
    assert_bad_size_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size != SZ_HALF) |=> (bus_rdata == '0));

    // Reads beyond the last register return zero
    assert_unmapped_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size == SZ_HALF && bus_addr > ADDR_W'(OFS_PEN))
        |=> (bus_rdata == '0));

endmodule

bind edge_gpio_ctrl gpio_ctrl_checker #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .irq       (irq),
    .status_q  (status_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .edge_set  (edge_set)
);

// File: tb/test_edge_gpio_ctrl.sv
// Directed bench for edge_gpio_ctrl: one task per scenario, each checking
// its own results against values worked out from the requirements.
module test_edge_gpio_ctrl;
    import gpio_ctrl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = SZ_HALF;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    edge_gpio_ctrl i_edge_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance n rising edges, then settle at the falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = SZ_HALF);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = SZ_HALF;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp,
                          input logic [1:0] sz = SZ_HALF);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_size = SZ_HALF;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset_values();
        check("R7 pin_out", pin_out, 16'h0000);
        check("R7 irq", {15'd0, irq}, 16'h0000);
        rd_chk("R7 out",  8'h04, 16'hFFFF);
        rd_chk("R7 dir",  8'h08, 16'hFFFF);
        rd_chk("R7 pol",  8'h0C, 16'hFFFF);
        rd_chk("R7 mask", 8'h10, 16'hFFFF);
        rd_chk("R7 stat", 8'h14, 16'h0000);
        rd_chk("R7 pen",  8'h18, 16'hFFFF);
        rd_chk("R7 in",   8'h00, 16'h0000);
    endtask

    task automatic t_output_gating();
        wr(8'h08, 16'h00FF);
        wr(8'h04, 16'hA5C3);
        check("R2 R10 gated out", pin_out, 16'hA500);
        wr(8'h08, 16'h0F0F);
        check("R2 dir change", pin_out, 16'hA0C0);
        wr(8'h08, 16'hFFFF);
        check("R2 all inputs", pin_out, 16'h0000);
    endtask

    task automatic t_input_read();
        pin_in = 16'h1234;
        edges(3);
        wr(8'h18, 16'h0F0F);
        rd_chk("R6 in AND pen", 8'h00, 16'h0204);
        wr(8'h00, 16'hFFFF);
        rd_chk("R6 in after write", 8'h00, 16'h0204);
        rd_chk("R6 pen after in write", 8'h18, 16'h0F0F);
        rd_chk("R10 read holds", 8'h04, 16'hA5C3);
        edges(2);
        check("R10 rdata held", bus_rdata, 16'hA5C3);
        wr(8'h18, 16'hFFFF);
        pin_in = 16'h0000;
        edges(4);
        wr(8'h14, 16'hFFFF);
    endtask

    task automatic t_rising_latency();
        wr(8'h0C, 16'hFFFF);
        wr(8'h10, 16'hFFFE);
        pin_in = 16'h0001;
        edges(3);
        check("R9 irq not yet", {15'd0, irq}, 16'h0000);
        edges(1);
        check("R9 irq raised", {15'd0, irq}, 16'h0001);
        rd_chk("R3 rising recorded", 8'h14, 16'h0001);
    endtask

    task automatic t_clear();
        wr(8'h14, 16'h0000);
        rd_chk("R5 zero write keeps", 8'h14, 16'h0001);
        wr(8'h14, 16'h0001);
        check("R5 irq one more cycle", {15'd0, irq}, 16'h0001);
        edges(1);
        check("R5 irq low", {15'd0, irq}, 16'h0000);
        rd_chk("R5 status clear", 8'h14, 16'h0000);
    endtask

    task automatic t_falling();
        wr(8'h0C, 16'hFFFB);
        wr(8'h10, 16'hFFFA);
        pin_in = 16'h0005;
        edges(5);
        rd_chk("R3 rise ignored on falling line", 8'h14, 16'h0000);
        pin_in = 16'h0001;
        edges(5);
        rd_chk("R3 fall recorded", 8'h14, 16'h0004);
        wr(8'h14, 16'h0004);
    endtask

    task automatic t_mask_discard();
        wr(8'h10, 16'hFFEF & 16'hFFDF | 16'h0010);
        pin_in = 16'h0011;
        edges(5);
        wr(8'h10, 16'hFFEF);
        edges(5);
        rd_chk("R4 masked edge dropped", 8'h14, 16'h0000);
        wr(8'h08, 16'hFFDF);
        wr(8'h10, 16'hFFDF);
        pin_in = 16'h0031;
        edges(5);
        rd_chk("R4 output line no event", 8'h14, 16'h0000);
        wr(8'h08, 16'hFFFF);
        wr(8'h10, 16'hFFFF);
    endtask

    task automatic t_set_wins();
        wr(8'h0C, 16'hFFFF);
        wr(8'h10, 16'hFFFE);
        pin_in = 16'h0030;
        edges(5);
        wr(8'h14, 16'hFFFF);
        pin_in = 16'h0031;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(8'h14, 16'h0001);
        rd_chk("R5 set wins over clear", 8'h14, 16'h0001);
        wr(8'h14, 16'h0001);
        rd_chk("R5 later clear works", 8'h14, 16'h0000);
    endtask

    task automatic t_bad_size();
        wr(8'h08, 16'h0000, SZ_WORD);
        check("R8 write ignored", pin_out, 16'h0000);
        rd_chk("R8 dir unchanged", 8'h08, 16'hFFFF);
        rd_chk("R8 byte read zero", 8'h08, 16'h0000, SZ_BYTE);
        rd_chk("R8 dword read zero", 8'h04, 16'h0000, SZ_DWORD);
    endtask

    task automatic t_unmapped();
        wr(8'h20, 16'h0000);
        wr(8'h1C, 16'h0000);
        rd_chk("R1 offset 0x1C zero", 8'h1C, 16'h0000);
        rd_chk("R1 offset 0x02 zero", 8'h02, 16'h0000);
        rd_chk("R1 out unchanged", 8'h04, 16'hA5C3);
        rd_chk("R1 mask unchanged", 8'h10, 16'hFFFE);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset_values();
        t_output_gating();
        t_input_read();
        t_rising_latency();
        t_clear();
        t_falling();
        t_mask_discard();
        t_set_wins();
        t_bad_size();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule